// File: doc/BRIEF.md
# Dual-counter performance monitor unit

This block is a per-processor event monitor. It holds two 32-bit event counters and one control register that serves both of them. Every cycle it looks at the processor's current privilege mode and at a bus of event strobes. A counter steps by one when the strobe for its selected event is high and the control register allows counting in the current mode. When a counter wraps from all ones to zero, a sticky overflow flag is set. An interrupt line is raised when a flagged counter also has its interrupt enable set.

Software reaches the unit through a small register port with a 64-bit data path and three registers: control, the counter pair, and overflow status. The mode enables in the control register apply to both counters at once, so neither counter can be stopped on its own. To idle a counter, software parks it on a reserved no-op event code that never counts. A counter can be preloaded with a negative period so that it overflows after a chosen number of events.

Top module: `evmon_dual`

## Requirements
- R1: After reset both event-select fields hold the no-op code 0x220, every other control bit is 0, both counters are 0, both status flags are 0 and `irq` is 0.
- R2: The control register is at address 0. The upper counter's 12-bit select is at bits 30:19, the lower counter's select is at bits 17:6, the user enable is bit 2, the hypervisor enable is bit 3, the supervisor enable is bit 4, and the upper/lower interrupt enables are bits 1/0. All other bits read as 0, and address 3 reads as 0.
- R3: Event code 0x200+k (k below the strobe count, 8 by default) selects strobe bit k. A counter steps by exactly one in a cycle where its selected strobe is high and counting is allowed. The two counters use their own selects and can step in the same cycle.
- R4: Counting is allowed only when the enable bit that matches `priv_mode` is set (0 = user, 1 = supervisor, 2 = hypervisor). Mode 3 never counts. With all three enables clear, both counters hold.
- R5: A counter whose select is the no-op code 0x220, or any code outside 0x200..0x207, never steps, whatever the strobes are.
- R6: The counter pair is at address 1: upper counter in bits 63:32, lower counter in bits 31:0. A write loads both halves at that clock edge and takes priority over a step in the same cycle.
- R7: A step from 0xFFFFFFFF to 0 sets that counter's sticky status flag (address 2: bit 1 upper, bit 0 lower). Writing 1 to a status bit clears it, and writing 0 leaves it alone. If a wrap and a clear of the same bit land in one cycle, the flag ends set.
- R8: `irq` is high exactly when some status flag is set and its interrupt enable is set. This holds even when the flagged counter is parked on the no-op code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 counters, 2 status |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data for `reg_addr`, combinational |
| priv_mode | input | 2 | Current privilege mode: 0 user, 1 supervisor, 2 hypervisor, 3 none |
| evt_strobe | input | NUM_EVT | One strobe per countable event |
| irq | output | 1 | Overflow interrupt request |

## Verification
The counters are driven with several strobe patterns:
- A single strobe versus two strobes, which shows that each counter follows only its own select.
- The same strobes under each privilege mode with different enable bits, which separates the user, supervisor and hypervisor bits from one another and from mode 3.
- All strobes high while both counters are parked or hold an out-of-range code, which separates the no-op code from real codes.

Preloads near the wrap point are used for several further checks:
- A preload written while a strobe is active shows that a load beats a step.
- A wrap with the interrupt enable off and then on, followed by parking the counter, shows that the interrupt does not depend on the event select.
- A wrap timed to land in the same cycle as a status clear shows that the set wins.

// File: rtl/evmon_pkg.sv
package evmon_pkg;

    localparam int CNT_W   = 32;
    localparam int NUM_CTR = 2;
    localparam int REG_W   = NUM_CTR * CNT_W;
    localparam int SEL_W   = 12;

    localparam int UP_SEL_LSB = 19;
    localparam int LO_SEL_LSB = 6;
    localparam int BIT_USR    = 2;
    localparam int BIT_HYP    = 3;
    localparam int BIT_SUP    = 4;

    localparam int IDX_UP = 1;
    localparam int IDX_LO = 0;

    localparam logic [SEL_W-1:0] NOP_CODE = 12'h220;
    localparam logic [SEL_W-1:0] EVT_BASE = 12'h200;

    typedef enum logic [1:0] {
        MODE_USER  = 2'd0,
        MODE_SUPER = 2'd1,
        MODE_HYPER = 2'd2,
        MODE_NONE  = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_CNT  = 2'd1,
        ADDR_STAT = 2'd2,
        ADDR_RSVD = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [SEL_W-1:0]   sel_up;
        logic [SEL_W-1:0]   sel_lo;
        logic               en_sup;
        logic               en_hyp;
        logic               en_usr;
        logic [NUM_CTR-1:0] ie;
    } ctrl_t;

    function automatic logic [REG_W-1:0] ctrl_pack(ctrl_t c);
        logic [REG_W-1:0] r;
        r = '0;
        r[UP_SEL_LSB +: SEL_W] = c.sel_up;
        r[LO_SEL_LSB +: SEL_W] = c.sel_lo;
        r[BIT_SUP]             = c.en_sup;
        r[BIT_HYP]             = c.en_hyp;
        r[BIT_USR]             = c.en_usr;
        r[NUM_CTR-1:0]         = c.ie;
        return r;
    endfunction

    function automatic ctrl_t ctrl_unpack(logic [REG_W-1:0] w);
        ctrl_t c;
        c.sel_up = w[UP_SEL_LSB +: SEL_W];
        c.sel_lo = w[LO_SEL_LSB +: SEL_W];
        c.en_sup = w[BIT_SUP];
        c.en_hyp = w[BIT_HYP];
        c.en_usr = w[BIT_USR];
        c.ie     = w[NUM_CTR-1:0];
        return c;
    endfunction

    function automatic logic mode_allows(ctrl_t c, priv_e m);
        case (m)
            MODE_USER:  return c.en_usr;
            MODE_SUPER: return c.en_sup;
            MODE_HYPER: return c.en_hyp;
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/evmon_ctrl.sv
module evmon_ctrl
    import evmon_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output ctrl_t            ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.sel_up <= NOP_CODE;
            ctrl_q.sel_lo <= NOP_CODE;
            ctrl_q.en_sup <= 1'b0;
            ctrl_q.en_hyp <= 1'b0;
            ctrl_q.en_usr <= 1'b0;
            ctrl_q.ie     <= '0;
        end else if (wr_en) begin
            ctrl_q <= ctrl_unpack(wdata);
        end
    end

endmodule

// File: rtl/evmon_counter.sv
module evmon_counter
    import evmon_pkg::*;
#(
    parameter int NUM_EVT = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_EVT-1:0] strobe,
    input  logic               mode_ok,
    input  logic               ld,
    input  logic [CNT_W-1:0]   ld_val,
    output logic [CNT_W-1:0]   cnt_q,
    output logic               wrap
);

    localparam int IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

    logic [SEL_W-1:0] off;
    logic             hit;
    logic             step;

    // event decode: codes EVT_BASE..EVT_BASE+NUM_EVT-1 map onto strobe bits
    always_comb begin
        off = sel - EVT_BASE;
        hit = 1'b0;
        if ((sel >= EVT_BASE) && (off < SEL_W'(NUM_EVT)))
            hit = strobe[off[IDX_W-1:0]];
    end

    assign step = hit && mode_ok && !ld;
    assign wrap = step && (&cnt_q);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (ld)
            cnt_q <= ld_val;
        else if (step)
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/evmon_status.sv
module evmon_status
    import evmon_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CTR-1:0] wrap,
    input  logic               clr_en,
    input  logic [NUM_CTR-1:0] clr_mask,
    input  logic [NUM_CTR-1:0] ie,
    output logic [NUM_CTR-1:0] st_q,
    output logic               irq
);

    logic [NUM_CTR-1:0] keep;

    assign keep = clr_en ? ~clr_mask : '1;

    // a wrap in the same cycle as a clear leaves the flag set
    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= (st_q & keep) | wrap;
    end

    assign irq = |(st_q & ie);

endmodule

// File: rtl/evmon_dual.sv
module evmon_dual
    import evmon_pkg::*;
#(
    parameter int NUM_EVT = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [1:0]         priv_mode,
    input  logic [NUM_EVT-1:0] evt_strobe,
    output logic               irq
);

    reg_addr_e                      addr_e;
    ctrl_t                          ctrl_q;
    logic                           mode_ok;
    logic                           ld_cnt;
    logic [NUM_CTR-1:0][SEL_W-1:0]  sel;
    logic [NUM_CTR-1:0][CNT_W-1:0]  cnt;
    logic [NUM_CTR-1:0]             wrap;
    logic [NUM_CTR-1:0]             st_q;

    assign addr_e  = reg_addr_e'(reg_addr);
    assign mode_ok = mode_allows(ctrl_q, priv_e'(priv_mode));
    assign ld_cnt  = reg_wr && (addr_e == ADDR_CNT);

    assign sel[IDX_UP] = ctrl_q.sel_up;
    assign sel[IDX_LO] = ctrl_q.sel_lo;

    evmon_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (reg_wr && (addr_e == ADDR_CTRL)),
        .wdata  (reg_wdata),
        .ctrl_q (ctrl_q)
    );

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        evmon_counter #(.NUM_EVT(NUM_EVT)) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .sel     (sel[g]),
            .strobe  (evt_strobe),
            .mode_ok (mode_ok),
            .ld      (ld_cnt),
            .ld_val  (reg_wdata[g*CNT_W +: CNT_W]),
            .cnt_q   (cnt[g]),
            .wrap    (wrap[g])
        );
    end

    evmon_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .wrap     (wrap),
        .clr_en   (reg_wr && (addr_e == ADDR_STAT)),
        .clr_mask (reg_wdata[NUM_CTR-1:0]),
        .ie       (ctrl_q.ie),
        .st_q     (st_q),
        .irq      (irq)
    );

    always_comb begin
        case (addr_e)
            ADDR_CTRL: reg_rdata = ctrl_pack(ctrl_q);
            ADDR_CNT:  reg_rdata = cnt;
            ADDR_STAT: reg_rdata = REG_W'(st_q);
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/evmon_dual_chk.sv
module evmon_dual_chk
    import evmon_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          reg_wr,
    input  logic [1:0]                    reg_addr,
    input  logic [REG_W-1:0]              reg_wdata,
    input  logic                          irq,
    input  logic                          mode_ok,
    input  logic [NUM_CTR-1:0][SEL_W-1:0] sel,
    input  logic [NUM_CTR-1:0][CNT_W-1:0] cnt,
    input  logic [NUM_CTR-1:0]            st_q
);

    logic ld;
    logic clr_up;
    logic clr_lo;

    assign ld     = reg_wr && (reg_addr == 2'd1);
    assign clr_up = reg_wr && (reg_addr == 2'd2) && reg_wdata[IDX_UP];
    assign clr_lo = reg_wr && (reg_addr == 2'd2) && reg_wdata[IDX_LO];

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (cnt == '0 && st_q == '0 && !irq));

    assert_step_up_R3: assert property (@(posedge clk) disable iff (rst)
        !ld |=> (cnt[IDX_UP] == $past(cnt[IDX_UP]) ||
                 cnt[IDX_UP] == $past(cnt[IDX_UP]) + 32'd1));

    assert_step_lo_R3: assert property (@(posedge clk) disable iff (rst)
        !ld |=> (cnt[IDX_LO] == $past(cnt[IDX_LO]) ||
                 cnt[IDX_LO] == $past(cnt[IDX_LO]) + 32'd1));

    assert_mode_gate_R4: assert property (@(posedge clk) disable iff (rst)
        (!mode_ok && !ld) |=> $stable(cnt));

    assert_nop_up_R5: assert property (@(posedge clk) disable iff (rst)
        (sel[IDX_UP] == NOP_CODE && !ld) |=> $stable(cnt[IDX_UP]));

    assert_nop_lo_R5: assert property (@(posedge clk) disable iff (rst)
        (sel[IDX_LO] == NOP_CODE && !ld) |=> $stable(cnt[IDX_LO]));

    assert_load_R6: assert property (@(posedge clk) disable iff (rst)
        ld |=> (cnt == $past(reg_wdata)));

    assert_wrap_up_R7: assert property (@(posedge clk) disable iff (rst)
        (!ld && cnt[IDX_UP] == '1) |=> (cnt[IDX_UP] != '0 || st_q[IDX_UP]));

    assert_sticky_up_R7: assert property (@(posedge clk) disable iff (rst)
        (st_q[IDX_UP] && !clr_up) |=> st_q[IDX_UP]);

    assert_sticky_lo_R7: assert property (@(posedge clk) disable iff (rst)
        (st_q[IDX_LO] && !clr_lo) |=> st_q[IDX_LO]);

    assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (st_q != '0));

endmodule

bind evmon_dual evmon_dual_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq       (irq),
    .mode_ok   (mode_ok),
    .sel       (sel),
    .cnt       (cnt),
    .st_q      (st_q)
);

// File: tb/evmon_dual_tb.sv
module evmon_dual_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_EVT      = 8;
    localparam logic [63:0] CMASK = 64'h0000_0000_7FFB_FFDF;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr = 1'b0;
    logic [1:0]        reg_addr = 2'd0;
    logic [63:0]       reg_wdata = '0;
    logic [63:0]       reg_rdata;
    logic [1:0]        priv_mode = 2'd0;
    logic [N_EVT-1:0]  evt_strobe = '0;
    logic              irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // reference model state
    logic [63:0] m_ctrl = 64'h0000_0000_1100_8800;
    logic [31:0] m_cnt [2] = '{32'd0, 32'd0};
    logic [1:0]  m_st = 2'b00;

    evmon_dual #(.NUM_EVT(N_EVT)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .priv_mode  (priv_mode),
        .evt_strobe (evt_strobe),
        .irq        (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit m_en();
        case (priv_mode)
            2'd0:    return m_ctrl[2];
            2'd1:    return m_ctrl[4];
            2'd2:    return m_ctrl[3];
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit m_hit(logic [11:0] s);
        int v;
        v = int'(s);
        if (v >= 512 && v < 512 + N_EVT) return evt_strobe[v-512];
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        logic [1:0] ov;
        bit ok;
        if (rst) begin
            m_ctrl = 64'h0000_0000_1100_8800;
            m_cnt[0] = '0;
            m_cnt[1] = '0;
            m_st = '0;
        end else begin
            ok = m_en();
            ov = 2'b00;
            if (reg_wr && reg_addr == 2'd1) begin
                m_cnt[1] = reg_wdata[63:32];
                m_cnt[0] = reg_wdata[31:0];
            end else begin
                for (int g = 0; g < 2; g++) begin
                    if (ok && m_hit(g == 1 ? m_ctrl[30:19] : m_ctrl[17:6])) begin
                        if (m_cnt[g] == 32'hFFFF_FFFF) ov[g] = 1'b1;
                        m_cnt[g] = m_cnt[g] + 32'd1;
                    end
                end
            end
            if (reg_wr && reg_addr == 2'd2) m_st = m_st & ~reg_wdata[1:0];
            m_st = m_st | ov;
            if (reg_wr && reg_addr == 2'd0) m_ctrl = reg_wdata & CMASK;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        logic [63:0] exp;
        if (!rst && !done) begin
            case (reg_addr)
                2'd0:    exp = m_ctrl;
                2'd1:    exp = {m_cnt[1], m_cnt[0]};
                2'd2:    exp = {62'd0, m_st};
                default: exp = '0;
            endcase
            tests++;
            if (reg_rdata !== exp) begin
                fails++;
                $display("FAIL model R2/R6/R7 addr %0d: got %h expected %h", reg_addr, reg_rdata, exp);
            end
            tests++;
            if (irq !== |(m_st & m_ctrl[1:0])) begin
                fails++;
                $display("FAIL model R8 irq: got %b expected %b", irq, |(m_st & m_ctrl[1:0]));
            end
        end
    end

    task automatic chk(input logic [1:0] a, input logic [63:0] exp, input string tag);
        @(posedge clk); #2;
        reg_addr = a;
        @(negedge clk); #1;
        tests++;
        if (reg_rdata !== exp) begin
            fails++;
            $display("FAIL %s addr %0d: got %h expected %h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        @(negedge clk); #1;
        tests++;
        if (irq !== exp) begin
            fails++;
            $display("FAIL %s irq: got %b expected %b", tag, irq, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [63:0] d);
        @(posedge clk); #2;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_wr = 1'b0;
    endtask

    task automatic pulse(input logic [N_EVT-1:0] s, input int n);
        @(posedge clk); #2;
        evt_strobe = s;
        repeat (n) @(posedge clk);
        #2 evt_strobe = '0;
    endtask

    function automatic logic [63:0] mk(logic [11:0] up, logic [11:0] lo, logic [4:0] low);
        return (64'(up) << 19) | (64'(lo) << 6) | 64'(low);
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        // R1 reset state
        chk(2'd0, 64'h0000_0000_1100_8800, "R1");
        chk(2'd1, 64'd0, "R1");
        chk(2'd2, 64'd0, "R1");
        chk_irq(1'b0, "R1");

        // R2 field layout, unused bits zero, reserved address zero
        wr(2'd0, '1);
        chk(2'd0, 64'h0000_0000_7FFB_FFDF, "R2");
        chk(2'd3, 64'd0, "R2");

        // R3 independent selects, user mode
        wr(2'd0, mk(12'h201, 12'h200, 5'b00100));
        priv_mode = 2'd0;
        pulse(8'b0000_0001, 5);
        pulse(8'b0000_0011, 3);
        chk(2'd1, {32'd3, 32'd8}, "R3");

        // R4 mode gating
        priv_mode = 2'd1;
        pulse(8'b0000_0011, 4);
        chk(2'd1, {32'd3, 32'd8}, "R4");
        wr(2'd0, mk(12'h201, 12'h200, 5'b01000));
        priv_mode = 2'd2;
        pulse(8'b0000_0011, 2);
        chk(2'd1, {32'd5, 32'd10}, "R4");
        wr(2'd0, mk(12'h201, 12'h200, 5'b11100));
        priv_mode = 2'd3;
        pulse(8'b0000_0011, 2);
        chk(2'd1, {32'd5, 32'd10}, "R4");
        wr(2'd0, mk(12'h201, 12'h200, 5'b10000));
        priv_mode = 2'd1;
        pulse(8'b0000_0011, 1);
        chk(2'd1, {32'd6, 32'd11}, "R4");

        // R5 parked and out-of-range codes
        wr(2'd0, mk(12'h220, 12'h220, 5'b11100));
        priv_mode = 2'd0;
        pulse(8'hFF, 4);
        chk(2'd1, {32'd6, 32'd11}, "R5");
        wr(2'd0, mk(12'h7FF, 12'h208, 5'b11100));
        pulse(8'hFF, 3);
        chk(2'd1, {32'd6, 32'd11}, "R5");

        // R6 load beats a step in the same cycle
        wr(2'd0, mk(12'h202, 12'h202, 5'b00100));
        @(posedge clk); #2;
        evt_strobe = 8'b0000_0100;
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 64'hFFFF_FFFE_0000_0010;
        @(posedge clk); #2;
        reg_wr = 1'b0; evt_strobe = '0;
        chk(2'd1, 64'hFFFF_FFFE_0000_0010, "R6");
        pulse(8'b0000_0100, 1);
        chk(2'd1, 64'hFFFF_FFFF_0000_0011, "R6");
        chk(2'd2, 64'd0, "R7");

        // R7 wrap sets upper flag; R8 gating by enable and parked counter
        pulse(8'b0000_0100, 1);
        chk(2'd1, 64'h0000_0000_0000_0012, "R7");
        chk(2'd2, 64'd2, "R7");
        chk_irq(1'b0, "R8");
        wr(2'd0, mk(12'h202, 12'h202, 5'b00110));
        chk_irq(1'b1, "R8");
        wr(2'd0, mk(12'h220, 12'h220, 5'b00110));
        chk_irq(1'b1, "R8");
        chk(2'd2, 64'd2, "R8");
        wr(2'd2, 64'd1);
        chk(2'd2, 64'd2, "R7");
        wr(2'd2, 64'd2);
        chk(2'd2, 64'd0, "R7");
        chk_irq(1'b0, "R8");

        // R7 wrap and clear in one cycle: set wins
        wr(2'd0, mk(12'h220, 12'h203, 5'b00101));
        wr(2'd1, {32'd5, 32'hFFFF_FFFF});
        @(posedge clk); #2;
        evt_strobe = 8'b0000_1000;
        reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 64'd1;
        @(posedge clk); #2;
        reg_wr = 1'b0; evt_strobe = '0;
        chk(2'd2, 64'd1, "R7");
        chk(2'd1, {32'd5, 32'd0}, "R3");
        chk_irq(1'b1, "R8");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule